// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Operation Decode

The block is a 4096-word by 8-bit memory shared by two independent ports, called left and right. Each port has a 12-bit address, byte-wide write data and byte-wide read data. Four active-low controls on each port select one operation per clock: chip enable, semaphore select, read/write (low means write) and output enable. An output-valid flag marks the cycles in which the read data holds a result. It takes the place of the tri-state drivers of a pad-level design.

A decoder in each port maps the four controls to one of seven operations: power-down, memory read, memory write, semaphore read, semaphore write, outputs off, or illegal. Semaphore reads and writes are not handled inside the block. They appear as strobes, an index and a write bit on a separate semaphore port, and an external flag store answers on that port.

Writes commit on the clock edge. Reads are registered. A port that reads the address the other port is writing in the same cycle receives the new write data through a bypass path. The block has no collision arbitration. Each port holds a sticky error flag that records any illegal combination of controls.

Top module: `dual_port_ram`

## Requirements
- R1: After reset, on both ports, read data is 0x00, output-valid is 0 and the error flag is 0.
- R2: A memory read (chip enable 0, semaphore select 1, read/write 1, output enable 0) sets output-valid in the next cycle and presents the byte last written at that address.
- R3: Both ports may read the same address in the same cycle, and both receive the stored byte.
- R4: A memory write (chip enable 0, semaphore select 1, read/write 0) stores the write byte at the address on the clock edge. With read/write at 1, the memory does not change.
- R5: Output-valid is 0 and read data is 0x00 in the cycle after any operation other than a read: power-down (chip enable 1, semaphore select 1), outputs off (read/write 1, output enable 1), or any write, whatever the level of output enable.
- R6: When one port writes an address and the other port reads the same address in the same cycle, the reader receives the new write byte in the next cycle.
- R7: A semaphore write (chip enable 1, semaphore select 0, read/write 0) raises the semaphore write strobe in that same cycle. The index is address bits [2:0] and the write bit is write-data bit 0. The memory is not modified.
- R8: A semaphore read (chip enable 1, semaphore select 0, read/write 1, output enable 0) raises the semaphore read strobe in that same cycle. In the next cycle, output-valid is 1 and all 8 read-data bits equal the semaphore bit returned in the strobe cycle.
- R9: Chip enable 0 together with semaphore select 0 is illegal. It writes neither the memory nor a semaphore, raises no strobe, and sets that port's error flag from the next cycle until reset. The other port's flag is not affected.
- R10: In power-down, neither semaphore strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw_n | input | 1 | Left read/write, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 12 | Left address |
| l_din | input | 8 | Left write data |
| l_dout | output | 8 | Left read data |
| l_dvld | output | 1 | Left read data valid |
| l_err | output | 1 | Left sticky illegal-control flag |
| l_sem_wr | output | 1 | Left semaphore write strobe |
| l_sem_rd | output | 1 | Left semaphore read strobe |
| l_sem_idx | output | 3 | Left semaphore index |
| l_sem_wbit | output | 1 | Left semaphore write bit |
| l_sem_rbit | input | 1 | Left semaphore value returned |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw_n | input | 1 | Right read/write, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 12 | Right address |
| r_din | input | 8 | Right write data |
| r_dout | output | 8 | Right read data |
| r_dvld | output | 1 | Right read data valid |
| r_err | output | 1 | Right sticky illegal-control flag |
| r_sem_wr | output | 1 | Right semaphore write strobe |
| r_sem_rd | output | 1 | Right semaphore read strobe |
| r_sem_idx | output | 3 | Right semaphore index |
| r_sem_wbit | output | 1 | Right semaphore write bit |
| r_sem_rbit | input | 1 | Right semaphore value returned |

## Verification
The semaphore strobe, index and write bit are combinational. The bench samples them one time unit after it drives the controls, inside the same cycle. Read data, output-valid and the error flag all pass through exactly one register. Their expected values are computed from the memory model as it stood before that cycle's writes, with the same-cycle opposite-port write substituted, and are compared one time unit after the next rising edge. Writes update the model only after the expected values for that cycle have been taken, so a read followed by a write lines up with the edge at which the design commits.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [2:0] {
    OP_PDN, OP_MRD, OP_MWR, OP_SRD, OP_SWR, OP_OFF, OP_ILL
  } port_op_e;

  // Map the four active-low controls of one port to a single operation.
  function automatic port_op_e decode_op(input logic ce_n, input logic sem_n,
                                         input logic rw_n, input logic oe_n);
    port_op_e op;
    if (!ce_n && !sem_n)     op = OP_ILL;
    else if (ce_n && sem_n)  op = OP_PDN;
    else if (!rw_n)          op = ce_n ? OP_SWR : OP_MWR;
    else if (!oe_n)          op = ce_n ? OP_SRD : OP_MRD;
    else                     op = OP_OFF;
    return op;
  endfunction

  // Bypass select: read hits the opposite port's same-cycle write.
  function automatic logic hits_opposite(input logic rd, input logic wr_opp,
                                         input logic [31:0] a_rd, input logic [31:0] a_wr);
    return rd && wr_opp && (a_rd == a_wr);
  endfunction
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
(
  input  logic ce_n,
  input  logic sem_n,
  input  logic rw_n,
  input  logic oe_n,
  output logic mem_we,
  output logic mem_re,
  output logic sem_we,
  output logic sem_re,
  output logic illegal
);
  port_op_e op;

  always_comb begin
    op      = decode_op(ce_n, sem_n, rw_n, oe_n);
    mem_we  = (op == OP_MWR);
    mem_re  = (op == OP_MRD);
    sem_we  = (op == OP_SWR);
    sem_re  = (op == OP_SRD);
    illegal = (op == OP_ILL);
  end
endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core
  import dpr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           we,
  input  logic [1:0]           re,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][DW-1:0]   wdata,
  output logic [1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Both ports commit on the edge; a same-address double write is undefined.
  always_ff @(posedge clk) begin
    if (we[0]) mem[addr[0]] <= wdata[0];
    if (we[1]) mem[addr[1]] <= wdata[1];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    localparam int Q = 1 - p;
    logic byp_hit;

    assign byp_hit = hits_opposite(re[p], we[Q], 32'(addr[p]), 32'(addr[Q]));

    always_ff @(posedge clk) begin
      if (re[p]) rdata[p] <= byp_hit ? wdata[Q] : mem[addr[p]];
    end

    // R6
    bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re[p] && we[Q] && (addr[p] == addr[Q])) |=> (rdata[p] == $past(wdata[Q])));
  end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_re,
  input  logic          sem_re,
  input  logic          illegal,
  input  logic [DW-1:0] mem_rdata,
  input  logic          sem_rbit,
  output logic [DW-1:0] dout,
  output logic          dvld,
  output logic          err
);
  logic sel_mem_q, sel_sem_q, sem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mem_q <= 1'b0;
      sel_sem_q <= 1'b0;
      sem_q     <= 1'b0;
      err       <= 1'b0;
    end else begin
      sel_mem_q <= mem_re;
      sel_sem_q <= sem_re;
      if (sem_re) sem_q <= sem_rbit;
      if (illegal) err <= 1'b1;
    end
  end

  assign dvld = sel_mem_q | sel_sem_q;
  assign dout = sel_mem_q ? mem_rdata :
                sel_sem_q ? {DW{sem_q}} : '0;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> err);
  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || sem_re) |=> dvld);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re || sem_re) |=> (!dvld && dout == '0));
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram #(
  parameter int AW   = 12,
  parameter int DW   = 8,
  parameter int SIDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            l_ce_n,
  input  logic            l_sem_n,
  input  logic            l_rw_n,
  input  logic            l_oe_n,
  input  logic [AW-1:0]   l_addr,
  input  logic [DW-1:0]   l_din,
  output logic [DW-1:0]   l_dout,
  output logic            l_dvld,
  output logic            l_err,
  output logic            l_sem_wr,
  output logic            l_sem_rd,
  output logic [SIDX-1:0] l_sem_idx,
  output logic            l_sem_wbit,
  input  logic            l_sem_rbit,
  input  logic            r_ce_n,
  input  logic            r_sem_n,
  input  logic            r_rw_n,
  input  logic            r_oe_n,
  input  logic [AW-1:0]   r_addr,
  input  logic [DW-1:0]   r_din,
  output logic [DW-1:0]   r_dout,
  output logic            r_dvld,
  output logic            r_err,
  output logic            r_sem_wr,
  output logic            r_sem_rd,
  output logic [SIDX-1:0] r_sem_idx,
  output logic            r_sem_wbit,
  input  logic            r_sem_rbit
);
  logic [1:0]           ce_n, sem_n, rw_n, oe_n, rbit;
  logic [1:0][AW-1:0]   addr;
  logic [1:0][DW-1:0]   din, dout, rdata;
  logic [1:0]           mem_we, mem_re, sem_we, sem_re, illegal, dvld, err;

  assign ce_n  = {r_ce_n,  l_ce_n};
  assign sem_n = {r_sem_n, l_sem_n};
  assign rw_n  = {r_rw_n,  l_rw_n};
  assign oe_n  = {r_oe_n,  l_oe_n};
  assign rbit  = {r_sem_rbit, l_sem_rbit};
  assign addr  = {r_addr, l_addr};
  assign din   = {r_din,  l_din};

  for (genvar p = 0; p < 2; p++) begin : g_port
    dpr_port_decode u_dec (
      .ce_n(ce_n[p]), .sem_n(sem_n[p]), .rw_n(rw_n[p]), .oe_n(oe_n[p]),
      .mem_we(mem_we[p]), .mem_re(mem_re[p]), .sem_we(sem_we[p]),
      .sem_re(sem_re[p]), .illegal(illegal[p])
    );

    dpr_port_out #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .mem_re(mem_re[p]), .sem_re(sem_re[p]),
      .illegal(illegal[p]), .mem_rdata(rdata[p]), .sem_rbit(rbit[p]),
      .dout(dout[p]), .dvld(dvld[p]), .err(err[p])
    );
  end

  dpr_mem_core #(.AW(AW), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re),
    .addr(addr), .wdata(din), .rdata(rdata)
  );

  assign l_dout     = dout[0];
  assign r_dout     = dout[1];
  assign l_dvld     = dvld[0];
  assign r_dvld     = dvld[1];
  assign l_err      = err[0];
  assign r_err      = err[1];
  assign l_sem_wr   = sem_we[0];
  assign r_sem_wr   = sem_we[1];
  assign l_sem_rd   = sem_re[0];
  assign r_sem_rd   = sem_re[1];
  assign l_sem_idx  = l_addr[SIDX-1:0];
  assign r_sem_idx  = r_addr[SIDX-1:0];
  assign l_sem_wbit = l_din[0];
  assign r_sem_wbit = r_din[0];

  // R9
  l_illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_sem_n) |-> (!l_sem_wr && !l_sem_rd));
  // R9
  r_illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_sem_n) |-> (!r_sem_wr && !r_sem_rd));
  // R10
  pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce_n && l_sem_n) |-> (!l_sem_wr && !l_sem_rd));
  // R5
  l_write_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_sem_n && !l_rw_n) |=> !l_dvld);
  // R5
  r_write_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && r_sem_n && !r_rw_n) |=> !r_dvld);
endmodule

// File: tb/tb_dual_port_ram.sv
`timescale 1ns/1ps
module tb_dual_port_ram;
  localparam int K_PDN = 0, K_MRD = 1, K_MWR = 2, K_SRD = 3, K_SWR = 4, K_OFF = 5, K_ILL = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] ce_n, sem_n, rw_n, oe_n, rbit;
  logic [11:0] addr [2];
  logic [7:0]  din [2];
  logic [7:0]  dout [2];
  logic [1:0]  dvld, err, swr, srd, swb;
  logic [2:0]  sidx [2];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [4096];
  logic [1:0] err_m;

  always #5 clk = ~clk;

  dual_port_ram dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(ce_n[0]), .l_sem_n(sem_n[0]), .l_rw_n(rw_n[0]), .l_oe_n(oe_n[0]),
    .l_addr(addr[0]), .l_din(din[0]), .l_dout(dout[0]), .l_dvld(dvld[0]),
    .l_err(err[0]), .l_sem_wr(swr[0]), .l_sem_rd(srd[0]), .l_sem_idx(sidx[0]),
    .l_sem_wbit(swb[0]), .l_sem_rbit(rbit[0]),
    .r_ce_n(ce_n[1]), .r_sem_n(sem_n[1]), .r_rw_n(rw_n[1]), .r_oe_n(oe_n[1]),
    .r_addr(addr[1]), .r_din(din[1]), .r_dout(dout[1]), .r_dvld(dvld[1]),
    .r_err(err[1]), .r_sem_wr(swr[1]), .r_sem_rd(srd[1]), .r_sem_idx(sidx[1]),
    .r_sem_wbit(swb[1]), .r_sem_rbit(rbit[1])
  );

  function automatic int kind(input logic c, input logic s, input logic w, input logic o);
    case ({c, s})
      2'b00:   return K_ILL;
      2'b11:   return K_PDN;
      2'b01:   return !w ? K_MWR : (o ? K_OFF : K_MRD);
      default: return !w ? K_SWR : (o ? K_OFF : K_SRD);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic setp(input int p, input logic c, input logic s, input logic w, input logic o,
                      input logic [11:0] a, input logic [7:0] d);
    ce_n[p] = c; sem_n[p] = s; rw_n[p] = w; oe_n[p] = o; addr[p] = a; din[p] = d;
  endtask

  // Inputs are set after a falling edge; checks strobes now, registers after the edge.
  task automatic step();
    int k [2];
    logic [7:0] ed [2];
    logic ev [2];
    string tg [2];
    #1;
    for (int p = 0; p < 2; p++) k[p] = kind(ce_n[p], sem_n[p], rw_n[p], oe_n[p]);
    for (int p = 0; p < 2; p++) begin
      chk($sformatf("R7 sem_wr p%0d", p), swr[p], k[p] == K_SWR);
      chk($sformatf("R8 sem_rd p%0d", p), srd[p], k[p] == K_SRD);
      if (k[p] == K_SWR) begin
        chk("R7 sem idx", sidx[p], addr[p][2:0]);
        chk("R7 sem bit", swb[p], din[p][0]);
      end
      ev[p] = 0; ed[p] = 8'h00; tg[p] = "R5 idle";
      if (k[p] == K_MRD) begin
        ev[p] = 1;
        if (k[1-p] == K_MWR && addr[1-p] == addr[p]) begin
          ed[p] = din[1-p]; tg[p] = "R6 bypass";
        end else begin
          ed[p] = model[addr[p]]; tg[p] = "R2 read";
        end
      end else if (k[p] == K_SRD) begin
        ev[p] = 1; ed[p] = {8{rbit[p]}}; tg[p] = "R8 sem read";
      end
      if (k[p] == K_ILL) err_m[p] = 1'b1;
    end
    for (int p = 0; p < 2; p++) if (k[p] == K_MWR) model[addr[p]] = din[p];
    @(posedge clk); #1;
    for (int p = 0; p < 2; p++) begin
      chk($sformatf("%s dvld p%0d", tg[p], p), dvld[p], ev[p]);
      chk($sformatf("%s dout p%0d", tg[p], p), dout[p], ed[p]);
      chk($sformatf("R9 err p%0d", p), err[p], err_m[p]);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h0d0a_1234));
    err_m = '0;
    rbit = '0;
    for (int p = 0; p < 2; p++) setp(p, 1, 1, 1, 1, 12'h000, 8'h00);
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 2; p++) begin
      chk("R1 reset dout", dout[p], 8'h00);
      chk("R1 reset dvld", dvld[p], 1'b0);
      chk("R1 reset err", err[p], 1'b0);
    end
    cyc(); rst_n = 1;

    // R4 preload window at the top of the array and both array ends
    for (int i = 0; i < 32; i++) begin
      cyc();
      setp(0, 0, 1, 0, $urandom % 2, 12'hFE0 + 12'(i), 8'($urandom));
      setp(1, 1, 1, 1, 1, 12'h000, 8'h00);
      step();
    end
    cyc(); setp(0, 0, 1, 0, 0, 12'h000, 8'h5A); setp(1, 0, 1, 0, 1, 12'hFFF, 8'hA5); step();

    // R3 both read the same word
    cyc(); setp(0, 0, 1, 1, 0, 12'hFFF, 8'h00); setp(1, 0, 1, 1, 0, 12'hFFF, 8'h00); step();
    // R6 left writes, right reads the same word
    cyc(); setp(0, 0, 1, 0, 0, 12'hFE3, 8'hC3); setp(1, 0, 1, 1, 0, 12'hFE3, 8'h00); step();
    // R4 no write with rw high, output enable high (R5 outputs off)
    cyc(); setp(0, 0, 1, 1, 1, 12'hFE4, 8'hEE); setp(1, 1, 1, 1, 1, 12'h000, 8'h00); step();
    cyc(); setp(0, 0, 1, 1, 0, 12'hFE4, 8'h00); step();
    // R7 semaphore write leaves memory alone
    cyc(); setp(0, 1, 0, 0, 0, 12'hFE5, 8'h01); step();
    cyc(); setp(0, 0, 1, 1, 0, 12'hFE5, 8'h00); step();
    // R8 semaphore read returning one
    cyc(); setp(0, 1, 0, 1, 0, 12'h006, 8'h00); rbit[0] = 1; step();
    // R9 illegal on right with rw low: no write, no strobe, err sticky
    cyc(); setp(0, 1, 1, 1, 1, 12'h000, 8'h00); setp(1, 0, 0, 0, 0, 12'hFE6, 8'h77); step();
    cyc(); setp(1, 0, 1, 1, 0, 12'hFE6, 8'h00); step();
    // R10 power-down on both
    cyc(); setp(0, 1, 1, 0, 0, 12'h007, 8'hFF); setp(1, 1, 1, 0, 0, 12'h007, 8'hFF); step();

    for (int n = 0; n < 3000; n++) begin
      int k [2];
      cyc();
      for (int p = 0; p < 2; p++) begin
        int m;
        logic c, s;
        m = $urandom % 10;
        if (m < 5)       begin c = 0; s = 1; end
        else if (m < 7)  begin c = 1; s = 0; end
        else if (m < 9)  begin c = 1; s = 1; end
        else if ($urandom % 8 == 0) begin c = 0; s = 0; end
        else             begin c = 0; s = 1; end
        setp(p, c, s, $urandom % 3 == 0 ? 1'b0 : 1'b1, $urandom % 4 == 0,
             12'hFE0 + 12'($urandom % 32), 8'($urandom));
        rbit[p] = 1'($urandom);
        k[p] = kind(ce_n[p], sem_n[p], rw_n[p], oe_n[p]);
      end
      if (k[0] == K_MWR && k[1] == K_MWR && addr[0] == addr[1]) rw_n[1] = 1;
      step();
    end

    // R1 reset clears the sticky flags
    cyc(); rst_n = 0;
    for (int p = 0; p < 2; p++) setp(p, 1, 1, 1, 1, 12'h000, 8'h00);
    @(posedge clk); #1;
    chk("R1 err clear l", err[0], 1'b0);
    chk("R1 err clear r", err[1], 1'b0);
    chk("R1 dvld clear", dvld, 2'b00);
    summary();
  end
endmodule